// File: doc/BRIEF.md
# Multi-drop parallel host link slave

This block sits on a board that shares a byte-wide parallel link with up to seven other boards, all hanging off one host adapter. A strapped 3-bit board number is compared against the select address that the host drives. The comparison counts only while the host marks the link as enabled and reports no power fault. A broadcast select overrides the comparison, so reset and interrupt commands can reach every board at once. While the board is selected, it places its pending data byte, request, interrupt and break handshakes onto the link. While it is not selected, all of them stay quiet.

On the local side, firmware loads a byte together with a write-request pulse, or a service code together with an interrupt-request pulse. Each request stays pending until the host acknowledges it while the board is selected. From the host control lines, the block decodes three commands. An immediate hard reset is decoded when interrupt-acknowledge is inactive. A one-cycle soft-reset pulse is produced once the reset line has been held long enough. A one-cycle level-7 interrupt strobe is produced on the release of the break line. Every host control input passes through a synchronizer before any decode.

Top module: `hpl_slave`

## Requirements
- R1: The board is selected when the synchronized host enable is 1, the synchronized power-fault flag is 0, and either the synchronized 3-bit host address equals `strap_addr` (bit 2 is the MSB) or the synchronized broadcast line is 1.
- R2: Every host control input passes through two flops before any decode. A change on a host line therefore reaches the outputs after the second rising clock edge, and not after the first.
- R3: A `lc_wr_req` pulse sets a pending write. `link_req` is 1 exactly while a write is pending and the board is selected.
- R4: A `lc_int_req` pulse loads `lc_data` as the service code and sets a pending interrupt. `link_int` and `link_brk` are both 1 exactly while an interrupt is pending and the board is selected. When both request pulses arrive in the same cycle, the service code is the byte that is held.
- R5: `link_data_oe` is 1 only while the board is selected and a write or an interrupt is pending. When it is 1, `link_data` carries the held byte. Otherwise `link_data` is 0.
- R6: A synchronized host acknowledge seen while the board is selected clears both pending requests. An acknowledge seen while the board is not selected leaves them pending.
- R7: `hard_rst` is 1 while the board is selected, the synchronized reset line is 1 and the synchronized interrupt-acknowledge line is 0.
- R8: `soft_rst` pulses high for exactly one cycle when the board has been selected with the synchronized reset line at 1 for LIMIT+1 consecutive cycles, where LIMIT = CLK_MHZ*HOLD_US (26 us). It does not pulse again until the hold is broken. A shorter hold produces no pulse.
- R9: `nmi_strobe` pulses high for one cycle when the synchronized break line falls from 1 to 0 while the board is selected.
- R10: With broadcast asserted, reset and interrupt commands act on a board whose address does not match.
- R11: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_addr | input | 3 | Strapped board number, bit 2 is the MSB |
| h_addr | input | 3 | Host select address |
| h_bcast | input | 1 | Host select-all line |
| h_en | input | 1 | Host enable |
| h_pwr_fault | input | 1 | Host power fault flag |
| h_reset | input | 1 | Host reset command line |
| h_break | input | 1 | Host break line (level-7 interrupt) |
| h_ack | input | 1 | Host acknowledge |
| h_inack | input | 1 | Host interrupt-acknowledge |
| lc_data | input | DATA_W | Local byte or service code |
| lc_wr_req | input | 1 | Local write request pulse |
| lc_int_req | input | 1 | Local interrupt request pulse |
| link_data | output | DATA_W | Byte driven toward the link |
| link_data_oe | output | 1 | Data buffer enable |
| link_req | output | 1 | Gated write request |
| link_int | output | 1 | Gated interrupt request |
| link_brk | output | 1 | Gated host-break request |
| soft_rst | output | 1 | One-cycle soft reset pulse |
| hard_rst | output | 1 | Hard reset level |
| nmi_strobe | output | 1 | One-cycle level-7 interrupt strobe |

## Verification
Selection is exercised with a matching address, a non-matching address, the broadcast line over a non-matching address, and a power fault. Together these separate the address compare from the enable and fault qualifiers. Acknowledges arrive both while the board is selected and while it is not, which shows whether gating applies to clearing as well as to visibility. The reset line is held once past the 26 us threshold and once well short of it, with interrupt-acknowledge at both levels, so that soft-reset timing can be told apart from hard-reset decode. Break pulses are sent to a selected board, to an unselected board, and under broadcast.

// File: rtl/hpl_pkg.sv
package hpl_pkg;
   localparam int ADDR_W = 3;

   typedef struct packed {
      logic              en;
      logic              fault;
      logic              rst;
      logic              brk;
      logic              ack;
      logic              inack;
      logic              bcast;
      logic [ADDR_W-1:0] addr;
   } host_ctl_t;
endpackage

// File: rtl/hpl_sync.sv
module hpl_sync #(
   parameter int WIDTH  = 10,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("hpl_sync needs at least two stages");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("hpl_sync width must be positive");
      end
   endgenerate

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         logic [WIDTH-1:0] r;
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) r <= '0;
               else        r <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) r <= '0;
               else        r <= g_stage[i-1].r;
            end
         end
      end
   endgenerate

   assign q = g_stage[STAGES-1].r;
endmodule

// File: rtl/hpl_select.sv
module hpl_select #(
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              fault,
   input  logic              bcast,
   input  logic              brk,
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] strap,
   output logic              sel,
   output logic              nmi
);
   logic brk_q;

   generate
      if (ADDR_W < 1) begin : g_bad_addr
         $error("hpl_select address width must be positive");
      end
   endgenerate

   assign sel = en & ~fault & ((addr == strap) | bcast);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) brk_q <= 1'b0;
      else        brk_q <= brk;
   end

   assign nmi = brk_q & ~brk & sel;

   // R9: the strobe never lasts two cycles
   p_nmi_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      nmi |=> !nmi);

   // R9: the strobe follows a break seen high one cycle earlier
   p_nmi_after_brk_r9: assert property (@(posedge clk) disable iff (!rst_n)
      nmi |-> $past(brk));
endmodule

// File: rtl/hpl_hold_timer.sv
module hpl_hold_timer #(
   parameter int LIMIT = 3250
) (
   input  logic clk,
   input  logic rst_n,
   input  logic held,
   output logic pulse
);
   localparam int CW = $clog2(LIMIT + 2);
   localparam logic [CW-1:0] SAT = CW'(LIMIT + 1);
   localparam logic [CW-1:0] HIT = CW'(LIMIT);

   logic [CW-1:0] cnt_q;

   generate
      if (LIMIT < 1) begin : g_bad_limit
         $error("hpl_hold_timer limit must be at least one");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (!held)         cnt_q <= '0;
      else if (cnt_q != SAT)  cnt_q <= cnt_q + 1'b1;
   end

   assign pulse = held & (cnt_q == HIT);

   // R8: one pulse per hold
   p_soft_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pulse |=> !pulse);

   // R8: a pulse needs the hold to have been present in the previous cycle
   p_soft_needs_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pulse |-> $past(held));
endmodule

// File: rtl/hpl_slave.sv
module hpl_slave
   import hpl_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int CLK_MHZ     = 125,
   parameter int HOLD_US     = 26,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] strap_addr,
   input  logic [ADDR_W-1:0] h_addr,
   input  logic              h_bcast,
   input  logic              h_en,
   input  logic              h_pwr_fault,
   input  logic              h_reset,
   input  logic              h_break,
   input  logic              h_ack,
   input  logic              h_inack,
   input  logic [DATA_W-1:0] lc_data,
   input  logic              lc_wr_req,
   input  logic              lc_int_req,
   output logic [DATA_W-1:0] link_data,
   output logic              link_data_oe,
   output logic              link_req,
   output logic              link_int,
   output logic              link_brk,
   output logic              soft_rst,
   output logic              hard_rst,
   output logic              nmi_strobe
);
   localparam int LIMIT = CLK_MHZ * HOLD_US;
   localparam int CTL_W = $bits(host_ctl_t);

   generate
      if (DATA_W < 1) begin : g_bad_data
         $error("hpl_slave data width must be positive");
      end
   endgenerate

   host_ctl_t        ctl_raw;
   host_ctl_t        ctl_s;
   logic [CTL_W-1:0] sync_q;
   logic             sel;
   logic             wr_pend_q, int_pend_q;
   logic [DATA_W-1:0] data_q;
   logic             clr;

   always_comb begin
      ctl_raw.en    = h_en;
      ctl_raw.fault = h_pwr_fault;
      ctl_raw.rst   = h_reset;
      ctl_raw.brk   = h_break;
      ctl_raw.ack   = h_ack;
      ctl_raw.inack = h_inack;
      ctl_raw.bcast = h_bcast;
      ctl_raw.addr  = h_addr;
   end

   hpl_sync #(.WIDTH(CTL_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (ctl_raw),
      .q     (sync_q)
   );

   assign ctl_s = host_ctl_t'(sync_q);

   hpl_select #(.ADDR_W(ADDR_W)) u_select (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (ctl_s.en),
      .fault (ctl_s.fault),
      .bcast (ctl_s.bcast),
      .brk   (ctl_s.brk),
      .addr  (ctl_s.addr),
      .strap (strap_addr),
      .sel   (sel),
      .nmi   (nmi_strobe)
   );

   hpl_hold_timer #(.LIMIT(LIMIT)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .held  (sel & ctl_s.rst),
      .pulse (soft_rst)
   );

   assign clr = sel & ctl_s.ack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_pend_q  <= 1'b0;
         int_pend_q <= 1'b0;
         data_q     <= '0;
      end else begin
         wr_pend_q  <= lc_wr_req  | (wr_pend_q  & ~clr);
         int_pend_q <= lc_int_req | (int_pend_q & ~clr);
         if (lc_int_req)      data_q <= lc_data;
         else if (lc_wr_req)  data_q <= lc_data;
      end
   end

   assign link_req     = wr_pend_q & sel;
   assign link_int     = int_pend_q & sel;
   assign link_brk     = int_pend_q & sel;
   assign link_data_oe = sel & (wr_pend_q | int_pend_q);
   assign link_data    = link_data_oe ? data_q : '0;
   assign hard_rst     = sel & ctl_s.rst & ~ctl_s.inack;

   // R3: a write request is pending one cycle after the local pulse
   p_set_pend_r3: assert property (@(posedge clk) disable iff (!rst_n)
      lc_wr_req |=> wr_pend_q);

   // R5: the buffer only opens for a selected board
   p_oe_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
      link_data_oe |-> sel);

   // R5: the held byte changes only on a local request
   p_data_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!lc_wr_req && !lc_int_req) |=> $stable(data_q));

   // R6: a selected acknowledge drops both requests
   p_ack_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !lc_wr_req && !lc_int_req) |=> (!wr_pend_q && !int_pend_q));
endmodule

// File: tb/tb_hpl_slave.sv
module tb_hpl_slave;
   localparam int LIMIT = 125 * 26;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] strap_addr = 3'b101;
   logic [2:0] h_addr = 3'b000;
   logic       h_bcast = 0, h_en = 0, h_pwr_fault = 0, h_reset = 0;
   logic       h_break = 0, h_ack = 0, h_inack = 0;
   logic [7:0] lc_data = 8'h00;
   logic       lc_wr_req = 0, lc_int_req = 0;
   logic [7:0] link_data;
   logic       link_data_oe, link_req, link_int, link_brk;
   logic       soft_rst, hard_rst, nmi_strobe;

   int checks = 0;
   int errors = 0;
   int soft_seen = 0;
   int nmi_seen = 0;
   int hard_seen = 0;
   bit started = 0;

   always #4 clk = ~clk;

   hpl_slave dut (
      .clk(clk), .rst_n(rst_n), .strap_addr(strap_addr), .h_addr(h_addr),
      .h_bcast(h_bcast), .h_en(h_en), .h_pwr_fault(h_pwr_fault),
      .h_reset(h_reset), .h_break(h_break), .h_ack(h_ack), .h_inack(h_inack),
      .lc_data(lc_data), .lc_wr_req(lc_wr_req), .lc_int_req(lc_int_req),
      .link_data(link_data), .link_data_oe(link_data_oe), .link_req(link_req),
      .link_int(link_int), .link_brk(link_brk), .soft_rst(soft_rst),
      .hard_rst(hard_rst), .nmi_strobe(nmi_strobe)
   );

   // behavioural reference: bit 9 en, 8 fault, 7 reset, 6 break, 5 ack,
   // 4 inack, 3 broadcast, 2:0 address
   bit [9:0] m_s1, m_s2;
   bit       m_wr, m_int, m_brk_prev;
   bit [7:0] m_data;
   int       m_cnt;

   function automatic bit m_sel(bit [9:0] v);
      return v[9] && !v[8] && ((v[2:0] == strap_addr) || v[3]);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_s1 = '0; m_s2 = '0; m_wr = 0; m_int = 0; m_brk_prev = 0;
         m_data = '0; m_cnt = 0;
      end else begin
         bit os, clr;
         os  = m_sel(m_s2);
         clr = os && m_s2[5];
         if (lc_int_req) begin m_int = 1; m_data = lc_data; end
         else if (clr) m_int = 0;
         if (lc_wr_req) begin m_wr = 1; if (!lc_int_req) m_data = lc_data; end
         else if (clr) m_wr = 0;
         if (os && m_s2[7]) begin if (m_cnt <= LIMIT) m_cnt++; end
         else m_cnt = 0;
         m_brk_prev = m_s2[6];
         m_s2 = m_s1;
         m_s1 = {h_en, h_pwr_fault, h_reset, h_break, h_ack, h_inack, h_bcast, h_addr};
      end
   end

   task automatic chk(bit ok, string tag, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      #2;
      if (started) begin
         bit s, e_oe, e_soft, e_nmi, e_hard;
         s      = m_sel(m_s2);
         e_oe   = s && (m_wr || m_int);
         e_soft = s && m_s2[7] && (m_cnt == LIMIT);
         e_nmi  = m_brk_prev && !m_s2[6] && s;
         e_hard = s && m_s2[7] && !m_s2[4];
         chk(link_req == (s && m_wr), "R3 link_req", link_req, s && m_wr);
         chk(link_int == (s && m_int) && link_brk == (s && m_int), "R4 link_int/link_brk",
             {link_int, link_brk}, {2{s && m_int}});
         chk(link_data_oe == e_oe, "R5 link_data_oe", link_data_oe, e_oe);
         chk(link_data == (e_oe ? m_data : 8'h00), "R5 link_data", link_data,
             e_oe ? m_data : 8'h00);
         chk(hard_rst == e_hard, "R7 hard_rst", hard_rst, e_hard);
         chk(soft_rst == e_soft, "R8 soft_rst", soft_rst, e_soft);
         chk(nmi_strobe == e_nmi, "R9 nmi_strobe", nmi_strobe, e_nmi);
         if (soft_rst) soft_seen++;
         if (nmi_strobe) nmi_seen++;
         if (hard_rst) hard_seen++;
      end
   end

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      finish_run();
   end

   initial begin
      cyc(3);
      rst_n = 1'b1;
      started = 1;
      cyc(1);
      // R11: reset state
      chk({link_data, link_data_oe, link_req, link_int, link_brk, soft_rst,
           hard_rst, nmi_strobe} == '0, "R11 reset outputs", link_data, 0);

      // pending write while not selected (address 0 against strap 5)
      h_en = 1; lc_data = 8'hA5; lc_wr_req = 1;
      cyc(1); lc_wr_req = 0; lc_data = 8'h00;
      cyc(3);
      chk(link_req == 0, "R3 hidden while unselected", link_req, 0);

      // R2: two edges of delay, R1: address match selects
      h_addr = 3'b101;
      @(posedge clk); #2;
      chk(link_req == 0, "R2 not after one edge", link_req, 0);
      @(posedge clk); #2;
      chk(link_req == 1, "R2 after two edges", link_req, 1);
      chk(link_data == 8'hA5, "R1 selected byte", link_data, 8'hA5);

      // R6: ack while unselected is ignored
      cyc(1); h_addr = 3'b011; cyc(3); h_ack = 1; cyc(4); h_ack = 0; cyc(3);
      h_addr = 3'b101; cyc(3);
      chk(link_req == 1, "R6 ack unselected ignored", link_req, 1);
      h_ack = 1; cyc(4); h_ack = 0; cyc(3);
      chk(link_req == 0, "R6 ack selected clears", link_req, 1'b0);

      // R4: both requests together, service code wins
      lc_data = 8'h3C; lc_int_req = 1; lc_wr_req = 1;
      cyc(1); lc_int_req = 0; lc_wr_req = 0; lc_data = 8'hFF; cyc(2);
      chk(link_data == 8'h3C && link_int && link_brk, "R4 code held", link_data, 8'h3C);

      // R1: power fault deselects
      h_pwr_fault = 1; cyc(4);
      chk(link_data_oe == 0, "R1 fault deselects", link_data_oe, 0);
      h_pwr_fault = 0; cyc(3);
      h_ack = 1; cyc(4); h_ack = 0; cyc(3);

      // R7: hard reset, and its suppression by interrupt-acknowledge
      hard_seen = 0;
      h_inack = 1; h_reset = 1; cyc(10); h_reset = 0; cyc(4);
      chk(hard_seen == 0, "R7 no hard with inack", hard_seen, 0);
      h_inack = 0; h_reset = 1; cyc(10); h_reset = 0; cyc(4);
      chk(hard_seen == 8 || hard_seen == 10, "R7 hard level", hard_seen, 10);

      // R8: long hold gives one pulse, short hold none
      h_inack = 1; soft_seen = 0;
      h_reset = 1; cyc(LIMIT + 60); h_reset = 0; cyc(4);
      chk(soft_seen == 1, "R8 one pulse on long hold", soft_seen, 1);
      soft_seen = 0;
      h_reset = 1; cyc(LIMIT / 2); h_reset = 0; cyc(4);
      chk(soft_seen == 0, "R8 no pulse on short hold", soft_seen, 0);

      // R9: break release on a selected board
      nmi_seen = 0;
      h_break = 1; cyc(5); h_break = 0; cyc(5);
      chk(nmi_seen == 1, "R9 nmi on release", nmi_seen, 1);

      // R10: unselected board ignores break, broadcast reaches it
      h_addr = 3'b010; cyc(3); nmi_seen = 0;
      h_break = 1; cyc(5); h_break = 0; cyc(5);
      chk(nmi_seen == 0, "R10 no nmi without broadcast", nmi_seen, 0);
      h_bcast = 1; cyc(3);
      h_break = 1; cyc(5); h_break = 0; cyc(5);
      chk(nmi_seen == 1, "R10 broadcast nmi", nmi_seen, 1);
      hard_seen = 0; h_inack = 0;
      h_reset = 1; cyc(6); h_reset = 0; cyc(4);
      chk(hard_seen > 0, "R10 broadcast hard reset", hard_seen, 1);
      h_bcast = 0; cyc(4);

      finish_run();
   end
endmodule